// File: doc/BRIEF.md
# DDR Write-Burst Read-Interrupt Sequencer

This block sits on the controller side of a double-data-rate SDRAM channel. It issues write and read commands and serialises a write burst onto the shared data lines as pairs of beats, one pair per clock. It drives the per-beat data mask, the strobe and the output enables of the data and strobe lines. A read request that arrives while a write burst is running cuts that burst short. The beats already driven are stored in memory. The sequencer masks the beats around the read command, drops the beats that remain, and frees the shared lines so they can turn around before read data comes back.

Read data is sampled a fixed CAS latency after the read command and returned one pair per clock on a valid/data port. A done flag marks the last pair. Refresh, activation, precharge, address mapping and pad timing belong to other blocks.

Top module: `ddr_wr_intr_seq`

## Requirements
- R1: A write request accepted in cycle A puts WRITE (code 1) with its bank on the command port in cycle A+1 (call it W). In W the strobe is enabled and held low (preamble) and the data lines are not driven.
- R2: An uninterrupted write drives data in clocks W+1 to W+BL/2. Clock W+k carries beats 2k-2 in the low half and 2k-1 in the high half, with mask 00 and the strobe toggling. Data and strobe enables are low again after W+BL/2.
- R3: A read accepted during a write burst in cycle a issues READ (code 2) with its bank in cycle a+2. A READ is never issued fewer than 2 clocks after the WRITE it interrupts.
- R4: When a read interrupts a write, the data clock just before the READ and the data clock of the READ both carry mask 11 with the strobe held still. The beats of earlier clocks are driven unmasked, and no later beat of the burst is driven.
- R5: In every clock after a READ command, the data and strobe enables are low, so both lines are released at least one clock before the first read data (CAS latency of at least 2).
- R6: For a READ in cycle R, the data input is sampled in cycles R+CL to R+CL+BL/2-1. Each sample appears on the read port with valid one clock later. The done flag is high together with the last of these pairs only.
- R7: Requests are accepted in idle. While a write burst runs, only a read is accepted, and only while the burst has at least two data clocks left (data clock index at most BL/2-2) and no read is pending. A write request during a burst sees ready low and has no effect on the burst.
- R8: The command port carries NOP (code 0) in every clock that is not a WRITE or READ clock.
- R9: After reset the block is idle and ready. Command is NOP, all enables are low, and valid and done are low.
- R10: A read accepted in idle issues READ in the next cycle and drives no write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_wdata | input | BL*BEAT_W | Write burst, beat 0 in the low bits |
| req_ready | output | 1 | Request accepted this cycle when valid |
| cmd | output | 2 | Command code: 0 NOP, 1 WRITE, 2 READ |
| cmd_bank | output | BANK_W | Bank of the current command |
| dq_out | output | 2*BEAT_W | Write beat pair, even beat in low half |
| dm_out | output | 2 | Per-beat mask, bit 0 for the even beat |
| dq_oe | output | 1 | Data line output enable |
| dqs_out | output | 1 | Strobe toggles this clock when high |
| dqs_oe | output | 1 | Strobe output enable |
| dq_in | input | 2*BEAT_W | Read beat pair from the data lines |
| rd_valid | output | 1 | Read pair valid |
| rd_data | output | 2*BEAT_W | Read beat pair |
| rd_done | output | 1 | Last pair of the read burst |

## Verification
The bench builds the block with burst length 8, CAS latency 2, 8-bit beats and 2 bank bits. At latency 2 the release margin is the tightest legal one, one clock, so any late release of the lines shows up. With four data clocks per burst, a read can be offered at every point in the burst: the first clock (no beat survives), the second and third clocks (partial bursts), and the first clock outside the acceptance window. A write offered mid-burst and a read from idle are also covered.

// File: rtl/ddrs_pkg.sv
// Shared encodings for the write/read-interrupt sequencer.
package ddrs_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/ddrs_sched.sv
// Command scheduler: accepts requests, issues WRITE/READ, tracks the
// write data clock index, holds a read that interrupts the burst and
// raises the mask flag for the clocks around the interrupting READ.
// Assumes BL is even and at least 4; cap_busy covers the read capture.
module ddrs_sched
    import ddrs_pkg::*;
#(
    parameter int BL     = 8,
    parameter int BANK_W = 2,
    localparam int PAIRS = BL / 2,
    localparam int CW    = $clog2(PAIRS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              cap_busy,
    output logic              req_ready,
    output logic              load,
    output logic [1:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              wr_act,
    output logic [CW-1:0]     wcnt,
    output logic              msk
);
    seq_st_e           st;
    logic              rd_pend;
    logic              rd_fired;
    logic [BANK_W-1:0] pend_bank;
    logic              win;
    logic              acc;
    logic              acc_rd_intr;
    logic              fire;

    // Acceptance window and handshake decode.
    always_comb begin
        win         = (st == ST_WRITE) && !rd_pend && !rd_fired &&
                      (wcnt <= CW'(PAIRS - 2));
        req_ready   = (st == ST_IDLE) || (win && !req_write);
        acc         = req_valid && req_ready;
        load        = acc && req_write && (st == ST_IDLE);
        acc_rd_intr = acc && (st == ST_WRITE);
        fire        = rd_pend && (wcnt >= CW'(1));
        wr_act      = (st == ST_WRITE);
    end

    // Sequencer state, command register and interrupt bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            wcnt      <= '0;
            rd_pend   <= 1'b0;
            rd_fired  <= 1'b0;
            msk       <= 1'b0;
            cmd       <= CMD_NOP;
            cmd_bank  <= '0;
            pend_bank <= '0;
        end else begin
            cmd <= CMD_NOP;
            case (st)
                ST_IDLE: begin
                    if (acc) begin
                        cmd_bank <= req_bank;
                        wcnt     <= '0;
                        if (req_write) begin
                            st  <= ST_WRITE;
                            cmd <= CMD_WRITE;
                        end else begin
                            st  <= ST_READ;
                            cmd <= CMD_READ;
                        end
                    end
                end
                ST_WRITE: begin
                    if (rd_fired) begin
                        st       <= ST_READ;
                        rd_fired <= 1'b0;
                        msk      <= 1'b0;
                    end else begin
                        wcnt <= wcnt + CW'(1);
                        if (acc_rd_intr) begin
                            rd_pend   <= 1'b1;
                            pend_bank <= req_bank;
                            msk       <= 1'b1;
                        end
                        if (fire) begin
                            cmd      <= CMD_READ;
                            cmd_bank <= pend_bank;
                            rd_pend  <= 1'b0;
                            rd_fired <= 1'b1;
                        end else if (wcnt == CW'(PAIRS) && !rd_pend) begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_READ: begin
                    if (!cap_busy) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: an interrupting READ comes at least two clocks after its WRITE.
    a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && rd_fired) |-> (wcnt >= CW'(2)));
endmodule

// File: rtl/ddrs_wr_drv.sv
// Write data driver: holds the burst, shifts out one beat pair per data
// clock, and drives mask, strobe and both output enables.
// Assumes the scheduler's clock index is 0 in the WRITE clock.
module ddrs_wr_drv #(
    parameter int BEAT_W = 8,
    parameter int BL     = 8,
    localparam int PAIRS  = BL / 2,
    localparam int CW     = $clog2(PAIRS + 1),
    localparam int PAIR_W = 2 * BEAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BL*BEAT_W-1:0] wdata,
    input  logic               wr_act,
    input  logic [CW-1:0]      wcnt,
    input  logic               msk,
    output logic [PAIR_W-1:0]  dq_out,
    output logic [1:0]         dm_out,
    output logic               dq_oe,
    output logic               dqs_out,
    output logic               dqs_oe
);
    logic [BL*BEAT_W-1:0] burst_q;

    // Burst register: load on accept, shift one pair per driven clock.
    always_ff @(posedge clk) begin
        if (!rst_n)       burst_q <= '0;
        else if (load)    burst_q <= wdata;
        else if (dq_oe)   burst_q <= burst_q >> PAIR_W;
    end

    // Pad-side drive decode from the scheduler state.
    always_comb begin
        dq_oe   = wr_act && (wcnt != '0);
        dqs_oe  = wr_act;
        dq_out  = dq_oe ? burst_q[PAIR_W-1:0] : '0;
        dm_out  = dq_oe ? {2{msk}} : 2'b00;
        dqs_out = dq_oe && !msk;
    end
endmodule

// File: rtl/ddrs_rd_cap.sv
// Read capture: counts from the READ command, samples the data input for
// BL/2 clocks starting CL clocks later, returns pairs with a done flag.
// Assumes CL >= 2.
module ddrs_rd_cap #(
    parameter int BEAT_W = 8,
    parameter int BL     = 8,
    parameter int CL     = 2,
    localparam int PAIRS  = BL / 2,
    localparam int LAST   = CL + PAIRS - 1,
    localparam int NW     = $clog2(LAST + 1),
    localparam int PAIR_W = 2 * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [PAIR_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [PAIR_W-1:0] rd_data,
    output logic              rd_done,
    output logic              busy
);
    logic [NW-1:0] cnt;

    // Latency counter and sampling of the returning beat pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            rd_valid <= 1'b0;
            rd_done  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            rd_done  <= 1'b0;
            if (rd_cmd) begin
                cnt <= NW'(1);
            end else if (cnt != '0) begin
                if (cnt >= NW'(CL)) begin
                    rd_valid <= 1'b1;
                    rd_data  <= dq_in;
                end
                if (cnt == NW'(LAST)) begin
                    rd_done <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + NW'(1);
                end
            end
        end
    end

    // Busy from the READ clock until the last sample is taken.
    always_comb busy = rd_cmd || (cnt != '0);

    // R6: the done pair is the last one, no pair follows it directly.
    a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_valid);
endmodule

// File: rtl/ddr_wr_intr_seq.sv
// Top of the write-burst read-interrupt sequencer. Wires the scheduler,
// write driver and read capture together. Assumes BL even >= 4, CL >= 2.
module ddr_wr_intr_seq
    import ddrs_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int BL     = 8,
    parameter int CL     = 2,
    parameter int BANK_W = 2,
    localparam int PAIRS  = BL / 2,
    localparam int CW     = $clog2(PAIRS + 1),
    localparam int PAIR_W = 2 * BEAT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [BL*BEAT_W-1:0] req_wdata,
    output logic                 req_ready,
    output logic [1:0]           cmd,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [PAIR_W-1:0]    dq_out,
    output logic [1:0]           dm_out,
    output logic                 dq_oe,
    output logic                 dqs_out,
    output logic                 dqs_oe,
    input  logic [PAIR_W-1:0]    dq_in,
    output logic                 rd_valid,
    output logic [PAIR_W-1:0]    rd_data,
    output logic                 rd_done
);
    logic          load;
    logic          wr_act;
    logic [CW-1:0] wcnt;
    logic          msk;
    logic          cap_busy;
    logic          rd_cmd;

    // READ command decode for the capture counter.
    always_comb rd_cmd = (cmd == CMD_READ);

    ddrs_sched #(.BL(BL), .BANK_W(BANK_W)) u_sched (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .cap_busy(cap_busy), .req_ready(req_ready), .load(load),
        .cmd(cmd), .cmd_bank(cmd_bank),
        .wr_act(wr_act), .wcnt(wcnt), .msk(msk)
    );

    ddrs_wr_drv #(.BEAT_W(BEAT_W), .BL(BL)) u_wr (
        .clk(clk), .rst_n(rst_n), .load(load), .wdata(req_wdata),
        .wr_act(wr_act), .wcnt(wcnt), .msk(msk),
        .dq_out(dq_out), .dm_out(dm_out), .dq_oe(dq_oe),
        .dqs_out(dqs_out), .dqs_oe(dqs_oe)
    );

    ddrs_rd_cap #(.BEAT_W(BEAT_W), .BL(BL), .CL(CL)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .dq_in(dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
        .busy(cap_busy)
    );

    // R1: the clock after a WRITE command carries the first data pair.
    a_r1_first_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd == CMD_WRITE) |-> dq_oe);

    // R4: a READ issued while data is driven follows a fully masked clock.
    a_r4_mask_before: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && dq_oe) |-> ($past(dm_out) == 2'b11));

    // R5: both lines are released in the clock after any READ.
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd == CMD_READ) |-> (!dq_oe && !dqs_oe));
endmodule

// File: tb/ddr_wr_intr_seq_test.sv
module ddr_wr_intr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int BEAT_W = 8;
    localparam int BL     = 8;
    localparam int CL     = 2;
    localparam int BANK_W = 2;
    localparam int PAIRS  = BL / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [BL*BEAT_W-1:0] req_wdata = '0;
    logic req_ready;
    logic [1:0] cmd;
    logic [BANK_W-1:0] cmd_bank;
    logic [2*BEAT_W-1:0] dq_out, dq_in, rd_data;
    logic [1:0] dm_out;
    logic dq_oe, dqs_out, dqs_oe, rd_valid, rd_done;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    int w_cyc = -100, r_cyc = -100, exp_r_cyc = -100;
    logic [BANK_W-1:0] exp_bank = '0;
    logic [1:0] prev_dm = 2'b00;
    int popped = 0;
    bit done_flag = 0;
    logic [BEAT_W-1:0] exp_wr[$], got_wr[$];
    logic [2*BEAT_W-1:0] exp_rd[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_wr_intr_seq #(.BEAT_W(BEAT_W), .BL(BL), .CL(CL), .BANK_W(BANK_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_wdata(req_wdata), .req_ready(req_ready),
        .cmd(cmd), .cmd_bank(cmd_bank), .dq_out(dq_out), .dm_out(dm_out),
        .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_oe(dqs_oe), .dq_in(dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor and memory model: everything sampled at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            // R6 read return scoreboard
            if (rd_valid) begin
                if (exp_rd.size() == 0) begin
                    check(0, "R6 unexpected pair", rd_data, 0);
                end else begin
                    logic [2*BEAT_W-1:0] e;
                    e = exp_rd.pop_front();
                    popped++;
                    check(rd_data == e, "R6 read data", rd_data, e);
                    check(rd_done == (popped == PAIRS), "R6 done flag", rd_done, popped == PAIRS);
                end
            end else begin
                check(!rd_done, "R6 done without valid", rd_done, 0);
            end
            // R8 legal codes only
            check(cmd != 2'b11, "R8 command code", cmd, 0);
            if (cmd == 2'd1) begin
                w_cyc = cyc;
                check(cmd_bank == exp_bank, "R1 write bank", cmd_bank, exp_bank);
                check(dqs_oe && !dqs_out && !dq_oe, "R1 preamble", {dqs_oe, dqs_out, dq_oe}, 3'b100);
            end
            if (dq_oe) begin
                check(dqs_oe && (cyc - w_cyc >= 1) && (cyc - w_cyc <= PAIRS),
                      "R2 data clock window", cyc - w_cyc, 1);
                if (dm_out == 2'b00) check(dqs_out, "R2 strobe toggles", dqs_out, 1);
                else check(dm_out == 2'b11 && !dqs_out, "R4 masked clock", {dm_out, dqs_out}, 3'b110);
                for (int b = 0; b < 2; b++)
                    if (!dm_out[b]) got_wr.push_back(dq_out[b*BEAT_W +: BEAT_W]);
            end
            if (cmd == 2'd2) begin
                r_cyc = cyc;
                popped = 0;
                check(cyc == exp_r_cyc, "R3/R10 read issue cycle", cyc, exp_r_cyc);
                check(cmd_bank == exp_bank, "R3 read bank", cmd_bank, exp_bank);
                if (dq_oe) begin
                    check(cyc - w_cyc >= 2, "R3 write-to-read spacing", cyc - w_cyc, 2);
                    check(prev_dm == 2'b11 && dm_out == 2'b11, "R4 mask around read",
                          {prev_dm, dm_out}, 4'hF);
                end
            end
            if (cyc > r_cyc && cyc < r_cyc + CL + 1)
                check(!dq_oe && !dqs_oe, "R5 bus released", {dq_oe, dqs_oe}, 0);
            // memory side: drive read pairs CL..CL+PAIRS-1 after READ
            if (cyc - r_cyc >= CL && cyc - r_cyc < CL + PAIRS) begin
                dq_in = 16'(r_cyc * 37 + (cyc - r_cyc) * 5 + 1);
                exp_rd.push_back(dq_in);
            end else begin
                dq_in = '0;
            end
            prev_dm = dm_out;
        end
    end

    task automatic settle();
        repeat (PAIRS + CL + 8) @(negedge clk);
        check(got_wr.size() == exp_wr.size(), "R2/R4 stored beat count", got_wr.size(), exp_wr.size());
        while (exp_wr.size() > 0 && got_wr.size() > 0) begin
            logic [BEAT_W-1:0] e, g;
            e = exp_wr.pop_front();
            g = got_wr.pop_front();
            check(g == e, "R2/R4 stored beat", g, e);
        end
        exp_wr.delete();
        got_wr.delete();
        check(exp_rd.size() == 0, "R6 all pairs returned", exp_rd.size(), 0);
        check(req_ready, "R7 idle after sequence", req_ready, 1);
    endtask

    // Driver: a write burst, optionally interrupted by a read offered d clocks
    // after the WRITE clock (d < 0 none, d > PAIRS-2 outside the window).
    task automatic run_write(input logic [BL*BEAT_W-1:0] data, input logic [BANK_W-1:0] wb,
                             input int d, input logic [BANK_W-1:0] rb, input bit try_write);
        int keep;
        @(negedge clk); #1;
        req_valid = 1; req_write = 1; req_bank = wb; req_wdata = data; exp_bank = wb;
        check(req_ready, "R7 ready in idle", req_ready, 1);
        @(negedge clk); #1;
        req_valid = 0;
        check(w_cyc == cyc, "R1 WRITE one clock after accept", w_cyc, cyc);
        keep = (d >= 0 && d <= PAIRS - 2) ? 2 * d : BL;
        for (int b = 0; b < keep; b++) exp_wr.push_back(data[b*BEAT_W +: BEAT_W]);
        if (try_write) begin
            @(negedge clk); #1;
            req_valid = 1; req_write = 1; req_bank = ~wb; req_wdata = ~data;
            #1 check(!req_ready, "R7 write refused in burst", req_ready, 0);
            req_valid = 0;
        end
        if (d >= 0) begin
            repeat (d) @(negedge clk);
            #1;
            req_valid = 1; req_write = 0; req_bank = rb;
            #1;
            if (d <= PAIRS - 2) begin
                check(req_ready, "R7 read ready in window", req_ready, 1);
                exp_bank = rb;
                exp_r_cyc = cyc + 2;
                @(negedge clk); #1;
            end else begin
                check(!req_ready, "R7 read refused late", req_ready, 0);
            end
            req_valid = 0;
        end
        settle();
    endtask

    task automatic run_read(input logic [BANK_W-1:0] rb);
        @(negedge clk); #1;
        req_valid = 1; req_write = 0; req_bank = rb; exp_bank = rb;
        check(req_ready, "R10 read ready in idle", req_ready, 1);
        exp_r_cyc = cyc + 1;
        @(negedge clk); #1;
        req_valid = 0;
        check(!dq_oe && !dqs_oe, "R10 no write drive", {dq_oe, dqs_oe}, 0);
        settle();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R9 reset state
        check(req_ready && cmd == 2'd0 && !dq_oe && !dqs_oe && !rd_valid && !rd_done,
              "R9 reset state", {req_ready, cmd, dq_oe, dqs_oe, rd_valid, rd_done}, 7'b1000000);
        run_write(64'h8877665544332211, 2'd1, -1, 2'd0, 1);  // R2, R7 full burst
        run_write(64'hF0E0D0C0B0A09080, 2'd2, 0, 2'd3, 0);   // R3, R4 nothing stored
        run_write(64'h1F2E3D4C5B6A7988, 2'd0, 1, 2'd1, 0);   // R4 two beats kept
        run_write(64'hA5A55A5AC3C33C3C, 2'd3, 2, 2'd2, 0);   // R4 four beats kept
        run_write(64'h0123456789ABCDEF, 2'd1, 3, 2'd0, 0);   // R7 late read refused
        run_read(2'd3);                                      // R10, R6
        run_write(64'h1122334455667788, 2'd2, 2, 2'd0, 0);   // R5 release again
        run_read(2'd0);
        finish_run();
    end
endmodule